// File: doc/BRIEF.md
# Virtqueue Request Fetcher

This block pulls one request out of a split virtqueue that lives in system memory. Software-side logic configures it with the log2 of the queue size and a 4 KiB page frame number. From these two values the block derives three base addresses: the descriptor table, the available ring and the used ring. It also keeps its own next-available counter.

Each start pulse makes the block compare the guest-published available index against that counter. If work is waiting, the block reads the head descriptor index from the available ring. It then walks the linked descriptors and files every segment as device-writable (IN) or device-readable (OUT). All memory traffic uses a single-outstanding read port. That port returns the aligned 64-bit little-endian word holding the requested address.

When the walk ends, the block pulses `done`. At that point the head index, the segment list and the IN/OUT counts are stable, and `empty` or `err` qualifies the result.

Top module: `vq_chain_walker`

## Requirements
- R1: After a configuration write with a non-zero page number P and size exponent K, `descBase` equals P·4096 and `availBase` equals `descBase` + 16·2^K.
- R2: `usedBase` equals `availBase` + 4 + 2·2^K rounded up to the next multiple of 4096.
- R3: Reset, or a configuration write with page number zero, clears all three bases and `nextAvail`. Any configuration write sets `nextAvail` to zero.
- R4: A start on a configured queue first reads the available index at `availBase`+2. If that index equals `nextAvail`, the block ends with `done` and `empty`, makes no further read and leaves `nextAvail` unchanged. A start with a zero descriptor base ends with `empty` and makes no read at all.
- R5: The head index is read at `availBase` + 4 + 2·(`nextAvail` mod 2^K). `nextAvail` then increments by one, wrapping at 16 bits.
- R6: The descriptor with index i is fetched as two reads, at `descBase`+16·(i mod 2^K) and 8 bytes higher. Its layout is: 64-bit address at byte 0, 32-bit length at byte 8, 16-bit flags at byte 12, 16-bit next index at byte 14. While flag bit 0 (NEXT) is set, the walk continues at the next index.
- R7: A descriptor with flag bit 1 (WRITE) set is recorded as an IN segment (`segIsIn`=1); otherwise it is recorded as OUT. Segments land in slots 0, 1, 2… in chain order. `segCount`, `inCount` and `outCount` restart at zero for every request.
- R8: When the eighth segment still has NEXT set, the block records it, raises `err` with `done`, and fetches no ninth descriptor.
- R9: `memReq` is a one-cycle pulse, with at most one read outstanding until `memValid` returns. The 16-bit value at address A is taken from bits 16·A[2:1] of `memData`.
- R10: Consecutive requests consume consecutive available-ring slots, and the slot number wraps modulo the queue size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWr | input | 1 | Load page number and size exponent (ignored while busy) |
| cfgPfn | input | 32 | Page frame number of the queue |
| qSizeLog2 | input | 4 | Queue size exponent K, size = 2^K |
| start | input | 1 | Fetch one request (taken while idle) |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse at the end of a fetch |
| empty | output | 1 | Last fetch found no request |
| err | output | 1 | Last fetch hit a chain longer than the segment slots |
| memReq | output | 1 | Read request pulse |
| memAddr | output | 64 | Byte address of the read |
| memValid | input | 1 | Read data valid |
| memData | input | 64 | Aligned little-endian word holding memAddr |
| descBase | output | 64 | Descriptor table base |
| availBase | output | 64 | Available ring base |
| usedBase | output | 64 | Used ring base |
| nextAvail | output | 16 | Local next-available counter |
| headIdx | output | 16 | Head descriptor index of the last request |
| segCount | output | 4 | Segments recorded |
| inCount | output | 4 | IN segments recorded |
| outCount | output | 4 | OUT segments recorded |
| segAddr | output | 8x64 | Segment addresses, slot 0 first |
| segLen | output | 8x32 | Segment lengths |
| segIsIn | output | 8 | Segment direction, 1 = IN |

## Verification
A corrupted base register or counter shows up on `memAddr` at the very next read pulse of the following request, well before `done`. Each read address is therefore logged and compared against the value computed from the page number, the size and the ring contents. A wrong current-descriptor index or a miscounted segment slot appears one read later as a stray descriptor address. It also appears at `done` as a mismatch in the segment list or the IN/OUT totals. A bad chain-length limit is exposed by the read count of an over-long chain, together with `err`.

// File: rtl/vq_walk_pkg.sv
package vq_walk_pkg;

  localparam int unsigned PAGE_SHIFT = 12;
  localparam int unsigned DESC_SHIFT = 4;   // 16-byte descriptors
  localparam int unsigned WORD_W     = 64;

  // which address the datapath places on the read port
  typedef enum logic [1:0] {
    SEL_RING_IDX,
    SEL_RING_ENT,
    SEL_DESC_LO,
    SEL_DESC_HI
  } addrSel_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_IDX_REQ,
    ST_IDX_WAIT,
    ST_ENT_REQ,
    ST_ENT_WAIT,
    ST_LO_REQ,
    ST_LO_WAIT,
    ST_HI_REQ,
    ST_HI_WAIT
  } walkState_e;

  // strobes from control to datapath
  typedef struct packed {
    addrSel_e addrSel;
    logic     newReq;
    logic     takeHead;
    logic     takeLo;
    logic     takeSeg;
  } dpCtl_t;

endpackage

// File: rtl/vq_walk_dp.sv
module vq_walk_dp
  import vq_walk_pkg::*;
#(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned PFN_W   = 32,
  parameter int unsigned LEN_W   = 32,
  parameter int unsigned MAX_SEG = 8,
  parameter int unsigned LOG2_W  = 4,
  localparam int unsigned CNT_W  = $clog2(MAX_SEG + 1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cfgWr,
  input  logic [PFN_W-1:0]              cfgPfn,
  input  logic [LOG2_W-1:0]             qSizeLog2,
  input  dpCtl_t                        ctl,
  input  logic                          memValid,
  input  logic [WORD_W-1:0]             memData,
  output logic [ADDR_W-1:0]             memAddr,
  output logic                          ringEmpty,
  output logic                          hasNext,
  output logic                          lastSlot,
  output logic                          configured,
  output logic [ADDR_W-1:0]             descBase,
  output logic [ADDR_W-1:0]             availBase,
  output logic [ADDR_W-1:0]             usedBase,
  output logic [15:0]                   nextAvail,
  output logic [15:0]                   headIdx,
  output logic [CNT_W-1:0]              segCount,
  output logic [CNT_W-1:0]              inCount,
  output logic [CNT_W-1:0]              outCount,
  output logic [MAX_SEG-1:0][WORD_W-1:0] segAddr,
  output logic [MAX_SEG-1:0][LEN_W-1:0] segLen,
  output logic [MAX_SEG-1:0]            segIsIn
);

  localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'((64'd1 << PAGE_SHIFT) - 64'd1);

  // ---------------- layout derivation ----------------
  logic [ADDR_W-1:0] ringSize, pageBase, ringBase, ringEnd, usedAligned;
  logic [16:0]       sizeFull;
  logic [15:0]       idxMask;

  always_comb begin
    ringSize    = ADDR_W'(1) << qSizeLog2;
    sizeFull    = 17'd1 << qSizeLog2;
    idxMask     = 16'(sizeFull - 17'd1);
    pageBase    = ADDR_W'(cfgPfn) << PAGE_SHIFT;
    ringBase    = pageBase + (ringSize << DESC_SHIFT);
    ringEnd     = ringBase + ADDR_W'(4) + (ringSize << 1);
    usedAligned = (ringEnd + PAGE_MASK) & ~PAGE_MASK;
  end

  // ---------------- walk registers ----------------
  logic [15:0]       curIdx;
  logic [WORD_W-1:0] loAddr;
  logic [15:0]       laneVal;
  logic [1:0]        laneSel;
  logic [15:0]       descFlags;
  logic [13:0]       flagsUnused;
  logic [ADDR_W-1:0] descAddr;

  assign laneSel     = memAddr[2:1];
  assign laneVal     = memData[{laneSel, 4'b0000} +: 16];
  assign descFlags   = memData[47:32];
  assign flagsUnused = descFlags[15:2];
  assign hasNext     = descFlags[0];
  assign ringEmpty   = (laneVal == nextAvail);
  assign lastSlot    = (segCount == CNT_W'(MAX_SEG - 1));
  assign configured  = (descBase != '0);
  assign descAddr    = descBase + (ADDR_W'(curIdx & idxMask) << DESC_SHIFT);

  always_comb begin
    unique case (ctl.addrSel)
      SEL_RING_IDX: memAddr = availBase + ADDR_W'(2);
      SEL_RING_ENT: memAddr = availBase + ADDR_W'(4) + (ADDR_W'(nextAvail & idxMask) << 1);
      SEL_DESC_LO:  memAddr = descAddr;
      default:      memAddr = descAddr + ADDR_W'(8);
    endcase
  end

  // configuration and ring counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descBase  <= '0;
      availBase <= '0;
      usedBase  <= '0;
      nextAvail <= '0;
    end else if (cfgWr) begin
      nextAvail <= '0;
      if (cfgPfn == '0) begin
        descBase  <= '0;
        availBase <= '0;
        usedBase  <= '0;
      end else begin
        descBase  <= pageBase;
        availBase <= ringBase;
        usedBase  <= usedAligned;
      end
    end else if (ctl.takeHead && memValid) begin
      nextAvail <= nextAvail + 16'd1;
    end
  end

  // chain state and counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headIdx  <= '0;
      curIdx   <= '0;
      loAddr   <= '0;
      segCount <= '0;
      inCount  <= '0;
      outCount <= '0;
    end else begin
      if (ctl.newReq) begin
        segCount <= '0;
        inCount  <= '0;
        outCount <= '0;
      end
      if (ctl.takeHead) begin
        headIdx <= laneVal;
        curIdx  <= laneVal;
      end
      if (ctl.takeLo) loAddr <= memData;
      if (ctl.takeSeg) begin
        segCount <= segCount + CNT_W'(1);
        if (descFlags[1]) inCount  <= inCount + CNT_W'(1);
        else              outCount <= outCount + CNT_W'(1);
        curIdx <= memData[63:48];
      end
    end
  end

  // segment slots
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segAddr <= '0;
      segLen  <= '0;
      segIsIn <= '0;
    end else if (ctl.takeSeg) begin
      for (int i = 0; i < int'(MAX_SEG); i++) begin
        if (segCount == CNT_W'(i)) begin
          segAddr[i] <= loAddr;
          segLen[i]  <= memData[LEN_W-1:0];
          segIsIn[i] <= descFlags[1];
        end
      end
    end
  end

  // ---------------- assertions ----------------
  p_used_aligned_r2: assert property (@(posedge clk) disable iff (!rstN)
    usedBase[PAGE_SHIFT-1:0] == '0);

  p_zero_pfn_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && cfgPfn == '0) |=> (descBase == '0 && availBase == '0 &&
                                 usedBase == '0 && nextAvail == '0));

  p_avail_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(nextAvail) |-> (nextAvail == $past(nextAvail) + 16'd1 || nextAvail == '0));

  p_split_sum_r7: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, inCount} + {1'b0, outCount}) == {1'b0, segCount});

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    segCount <= CNT_W'(MAX_SEG));

  p_busy_config_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.takeSeg) |-> configured);

endmodule

// File: rtl/vq_walk_ctrl.sv
module vq_walk_ctrl
  import vq_walk_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   memValid,
  input  logic   ringEmpty,
  input  logic   hasNext,
  input  logic   lastSlot,
  input  logic   configured,
  output dpCtl_t ctl,
  output logic   memReq,
  output logic   busy,
  output logic   done,
  output logic   empty,
  output logic   err
);

  walkState_e state;

  always_comb begin
    ctl = '0;
    unique case (state)
      ST_IDX_REQ, ST_IDX_WAIT: ctl.addrSel = SEL_RING_IDX;
      ST_ENT_REQ, ST_ENT_WAIT: ctl.addrSel = SEL_RING_ENT;
      ST_LO_REQ,  ST_LO_WAIT:  ctl.addrSel = SEL_DESC_LO;
      ST_HI_REQ,  ST_HI_WAIT:  ctl.addrSel = SEL_DESC_HI;
      default:                 ctl.addrSel = SEL_RING_IDX;
    endcase
    ctl.newReq   = (state == ST_IDLE) && start && configured;
    ctl.takeHead = (state == ST_ENT_WAIT) && memValid;
    ctl.takeLo   = (state == ST_LO_WAIT) && memValid;
    ctl.takeSeg  = (state == ST_HI_WAIT) && memValid;
  end

  assign memReq = (state == ST_IDX_REQ) || (state == ST_ENT_REQ) ||
                  (state == ST_LO_REQ)  || (state == ST_HI_REQ);
  assign busy   = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      empty <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          err <= 1'b0;
          if (configured) begin
            empty <= 1'b0;
            state <= ST_IDX_REQ;
          end else begin
            empty <= 1'b1;
            done  <= 1'b1;
          end
        end
        ST_IDX_REQ: state <= ST_IDX_WAIT;
        ST_IDX_WAIT: if (memValid) begin
          if (ringEmpty) begin
            empty <= 1'b1;
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            state <= ST_ENT_REQ;
          end
        end
        ST_ENT_REQ: state <= ST_ENT_WAIT;
        ST_ENT_WAIT: if (memValid) state <= ST_LO_REQ;
        ST_LO_REQ:   state <= ST_LO_WAIT;
        ST_LO_WAIT:  if (memValid) state <= ST_HI_REQ;
        ST_HI_REQ:   state <= ST_HI_WAIT;
        ST_HI_WAIT: if (memValid) begin
          if (hasNext && !lastSlot) begin
            state <= ST_LO_REQ;
          end else begin
            err   <= hasNext;
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_empty_stop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDX_WAIT && memValid && ringEmpty) |=> (state == ST_IDLE && empty && done));

  p_err_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(err) |-> done);

endmodule

// File: rtl/vq_chain_walker.sv
module vq_chain_walker
  import vq_walk_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWr,
  input  logic [31:0]        cfgPfn,
  input  logic [3:0]         qSizeLog2,
  input  logic               start,
  output logic               busy,
  output logic               done,
  output logic               empty,
  output logic               err,
  output logic               memReq,
  output logic [63:0]        memAddr,
  input  logic               memValid,
  input  logic [63:0]        memData,
  output logic [63:0]        descBase,
  output logic [63:0]        availBase,
  output logic [63:0]        usedBase,
  output logic [15:0]        nextAvail,
  output logic [15:0]        headIdx,
  output logic [3:0]         segCount,
  output logic [3:0]         inCount,
  output logic [3:0]         outCount,
  output logic [7:0][63:0]   segAddr,
  output logic [7:0][31:0]   segLen,
  output logic [7:0]         segIsIn
);

  dpCtl_t ctl;
  logic   ringEmpty, hasNext, lastSlot, configured;
  logic   cfgWrIdle;

  assign cfgWrIdle = cfgWr && !busy;

  vq_walk_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .memValid   (memValid),
    .ringEmpty  (ringEmpty),
    .hasNext    (hasNext),
    .lastSlot   (lastSlot),
    .configured (configured),
    .ctl        (ctl),
    .memReq     (memReq),
    .busy       (busy),
    .done       (done),
    .empty      (empty),
    .err        (err)
  );

  vq_walk_dp #(
    .ADDR_W (64),
    .PFN_W  (32),
    .LEN_W  (32),
    .MAX_SEG(8),
    .LOG2_W (4)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWr      (cfgWrIdle),
    .cfgPfn     (cfgPfn),
    .qSizeLog2  (qSizeLog2),
    .ctl        (ctl),
    .memValid   (memValid),
    .memData    (memData),
    .memAddr    (memAddr),
    .ringEmpty  (ringEmpty),
    .hasNext    (hasNext),
    .lastSlot   (lastSlot),
    .configured (configured),
    .descBase   (descBase),
    .availBase  (availBase),
    .usedBase   (usedBase),
    .nextAvail  (nextAvail),
    .headIdx    (headIdx),
    .segCount   (segCount),
    .inCount    (inCount),
    .outCount   (outCount),
    .segAddr    (segAddr),
    .segLen     (segLen),
    .segIsIn    (segIsIn)
  );

endmodule

// File: tb/vq_chain_walker_test.sv
module vq_chain_walker_test;

  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cfgWr = 1'b0;
  logic [31:0]      cfgPfn = '0;
  logic [3:0]       qSizeLog2 = '0;
  logic             start = 1'b0;
  logic             busy, done, empty, err, memReq;
  logic [63:0]      memAddr;
  logic             memValid = 1'b0;
  logic [63:0]      memData = '0;
  logic [63:0]      descBase, availBase, usedBase;
  logic [15:0]      nextAvail, headIdx;
  logic [3:0]       segCount, inCount, outCount;
  logic [7:0][63:0] segAddr;
  logic [7:0][31:0] segLen;
  logic [7:0]       segIsIn;

  int nChecks = 0;
  int nBad = 0;
  logic [63:0] mem [longint unsigned];
  logic [63:0] rdLog [0:63];
  int rdCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vq_chain_walker uut (.*);

  function automatic logic [63:0] rd64(input logic [63:0] a);
    longint unsigned k = longint'(a >> 3);
    return mem.exists(k) ? mem[k] : 64'd0;
  endfunction

  task automatic wr64(input logic [63:0] a, input logic [63:0] v);
    mem[longint'(a >> 3)] = v;
  endtask

  task automatic wr16(input logic [63:0] a, input logic [15:0] v);
    logic [63:0] w = rd64(a);
    int sh = int'(a[2:1]) * 16;
    w[sh +: 16] = v;
    wr64(a, w);
  endtask

  task automatic wrDesc(input logic [63:0] base, input int idx, input logic [63:0] addr,
                        input logic [31:0] len, input logic [15:0] flags, input logic [15:0] nxt);
    logic [63:0] a = base + 64'(idx) * 64'd16;
    wr64(a, addr);
    wr64(a + 64'd8, {nxt, flags, len});
  endtask

  // memory responder: request seen at one falling edge, data at the next
  initial begin
    forever begin
      @(negedge clk);
      memValid = 1'b0;
      if (memReq === 1'b1) begin
        if (rdCnt < 64) rdLog[rdCnt] = memAddr;
        rdCnt++;
        memData = rd64({memAddr[63:3], 3'b000});
        @(negedge clk);
        memValid = 1'b1;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [31:0] pfn, input logic [3:0] k);
    @(negedge clk);
    cfgPfn = pfn; qSizeLog2 = k; cfgWr = 1'b1;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic runReq();
    int guard = 0;
    rdCnt = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (done !== 1'b1 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    chk("R4 done reached", 64'(done), 64'd1);
  endtask

  task automatic t_reset();
    chk("R3 reset descBase", descBase, 0);
    chk("R3 reset usedBase", usedBase, 0);
    chk("R3 reset nextAvail", 64'(nextAvail), 0);
    chk("R9 reset memReq", 64'(memReq), 0);
    chk("R4 reset busy", 64'(busy), 0);
  endtask

  task automatic t_unconfigured();
    runReq();
    chk("R4 unconfigured empty", 64'(empty), 1);
    chk("R4 unconfigured no read", 64'(rdCnt), 0);
  endtask

  task automatic t_layout();
    cfg(32'd2, 4'd8);
    chk("R1 descBase k8", descBase, 64'h2000);
    chk("R1 availBase k8", availBase, 64'h3000);
    chk("R2 usedBase k8", usedBase, 64'h4000);
    cfg(32'd5, 4'd3);
    chk("R1 descBase k3", descBase, 64'h5000);
    chk("R1 availBase k3", availBase, 64'h5080);
    chk("R2 usedBase k3", usedBase, 64'h6000);
  endtask

  task automatic t_empty();
    wr16(64'h5082, 16'd0);
    runReq();
    chk("R4 empty flag", 64'(empty), 1);
    chk("R4 one read", 64'(rdCnt), 1);
    chk("R4 idx address", rdLog[0], 64'h5082);
    chk("R4 counter kept", 64'(nextAvail), 0);
  endtask

  task automatic t_chain();
    wr16(64'h5082, 16'd1);
    wr16(64'h5084, 16'd3);
    wrDesc(64'h5000, 3, 64'h1111_0000, 32'd100, 16'h0001, 16'd5);
    wrDesc(64'h5000, 5, 64'h2222, 32'd200, 16'h0003, 16'd9);
    wrDesc(64'h5000, 1, 64'h3333, 32'd300, 16'h0002, 16'd0);
    runReq();
    chk("R4 not empty", 64'(empty), 0);
    chk("R5 head index", 64'(headIdx), 3);
    chk("R5 counter step", 64'(nextAvail), 1);
    chk("R5 entry address", rdLog[1], 64'h5084);
    chk("R6 first desc lo", rdLog[2], 64'h5030);
    chk("R6 first desc hi", rdLog[3], 64'h5038);
    chk("R6 second desc", rdLog[4], 64'h5050);
    chk("R6 next index reduced", rdLog[6], 64'h5010);
    chk("R6 read total", 64'(rdCnt), 8);
    chk("R7 seg count", 64'(segCount), 3);
    chk("R7 in count", 64'(inCount), 2);
    chk("R7 out count", 64'(outCount), 1);
    chk("R7 slot0 addr", segAddr[0], 64'h1111_0000);
    chk("R7 slot0 out", 64'(segIsIn[0]), 0);
    chk("R7 slot1 len", 64'(segLen[1]), 200);
    chk("R7 slot1 in", 64'(segIsIn[1]), 1);
    chk("R7 slot2 addr", segAddr[2], 64'h3333);
    chk("R8 no error", 64'(err), 0);
  endtask

  task automatic t_single();
    wr16(64'h5082, 16'd2);
    wr16(64'h5086, 16'd0);
    wrDesc(64'h5000, 0, 64'h4444, 32'd64, 16'h0000, 16'd7);
    runReq();
    chk("R5 second entry address", rdLog[1], 64'h5086);
    chk("R5 head second", 64'(headIdx), 0);
    chk("R7 count restart", 64'(segCount), 1);
    chk("R7 in restart", 64'(inCount), 0);
    chk("R7 slot0 addr second", segAddr[0], 64'h4444);
    chk("R6 stop without next", 64'(rdCnt), 4);
    runReq();
    chk("R4 empty after catch-up", 64'(empty), 1);
    chk("R4 counter after catch-up", 64'(nextAvail), 2);
  endtask

  task automatic t_long();
    cfg(32'd7, 4'd4);
    chk("R3 counter cleared by config", 64'(nextAvail), 0);
    wr16(64'h7102, 16'd1);
    wr16(64'h7104, 16'd0);
    for (int i = 0; i < 10; i++)
      wrDesc(64'h7000, i, 64'(32'hA000 + i), 32'(i + 1), (i % 2 == 1) ? 16'h0003 : 16'h0001,
             16'(i + 1));
    runReq();
    chk("R8 error flag", 64'(err), 1);
    chk("R8 segments capped", 64'(segCount), 8);
    chk("R8 no ninth fetch", 64'(rdCnt), 18);
    chk("R8 in split", 64'(inCount), 4);
    chk("R8 last slot addr", segAddr[7], 64'hA007);
  endtask

  task automatic t_wrap();
    cfg(32'd9, 4'd2);
    chk("R2 usedBase k2", usedBase, 64'hA000);
    wr16(64'h9042, 16'd5);
    for (int k = 0; k < 4; k++) begin
      wr16(64'h9044 + 64'(2 * k), 16'(k + 8));
      wrDesc(64'h9000, k, 64'(k), 32'd4, 16'h0000, 16'd0);
    end
    wr16(64'h9044, 16'd2);
    for (int n = 0; n < 4; n++) runReq();
    wr16(64'h9044, 16'd3);
    runReq();
    chk("R10 wrapped slot address", rdLog[1], 64'h9044);
    chk("R10 wrapped head", 64'(headIdx), 3);
    chk("R10 counter after five", 64'(nextAvail), 5);
  endtask

  task automatic t_zero_pfn();
    cfg(32'd0, 4'd2);
    chk("R3 zero pfn desc", descBase, 0);
    chk("R3 zero pfn avail", availBase, 0);
    chk("R3 zero pfn used", usedBase, 0);
    chk("R3 zero pfn counter", 64'(nextAvail), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_unconfigured();
    t_layout();
    t_empty();
    t_chain();
    t_single();
    t_long();
    t_wrap();
    t_zero_pfn();
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule